// File: doc/BRIEF.md
# Cascadable Content-Addressable Memory with Chain Status Flags

This block is a small synchronous content-addressable memory. Each entry of the main array holds a key word and a validity bit. A second, smaller table of keys sits beside the main array, and a compare searches both at once. A write port loads one entry of either store, and the entry's validity bit comes from the same write. A compare presents a key. On the next clock edge the block publishes whether anything hit, which store produced the hit, and a saturated count of main-array hits.

Several copies can be stacked by priority. The full indication is chained: each device passes its active-low full output to the full input of the next device down, and the top device has its full input tied low. The multiple-match indication is a shared wired-AND line. Each device drives a pull-down enable onto that line. The threshold for pulling drops from two local hits to one when a higher-priority device reports a match on the upstream match input.

Top module: `cam_cascade`

## Requirements
- R1: While `rst_ni` is low, every entry of both stores is invalid, `full_n_o` = 1, `match_n_o` = 1, `hit_aux_o` = 0 and `mm_pull_o` = 0. A compare issued right after reset matches nothing, even for key 0.
- R2: A write with `wr_aux_i` = 0 loads `wr_data_i` and `wr_valid_i` into main entry `wr_addr_i`. A write with `wr_aux_i` = 1 loads them into auxiliary entry `wr_addr_i` modulo the auxiliary depth. A compare issued in the same cycle as a write searches the contents as they were before that write.
- R3: Only entries whose validity bit is 1 take part in a compare. An entry written with `wr_valid_i` = 0 no longer matches.
- R4: One edge after a compare, `match_n_o` is 0 if the main array or the auxiliary table holds the key, and 1 only if both miss. `mm_up_ni` has no effect on it.
- R5: `hit_aux_o` is 1 only when the last compare missed the main array and hit the auxiliary table. A main-array hit takes precedence and gives 0.
- R6: With `mm_up_ni` = 1, `mm_pull_o` is 1 exactly when the last compare hit two or more valid main entries.
- R7: With `mm_up_ni` = 0, `mm_pull_o` is 1 exactly when the last compare hit one or more valid main entries. The threshold follows `mm_up_ni` within the same cycle.
- R8: Hits in the auxiliary table never count toward `mm_pull_o`.
- R9: On a write edge, `full_n_o` becomes 0 if, after that write, every main entry is valid and `full_ni` is 0. Otherwise it becomes 1, so `full_ni` = 1 forces it to 1. Auxiliary entries do not count toward fullness.
- R10: `full_n_o` changes only on edges that carry a write. `match_n_o`, `hit_aux_o` and the stored hit count change only on edges that carry a compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_aux_i | input | 1 | Write target: 1 selects the auxiliary table, 0 the main array |
| wr_addr_i | input | clog2(ENTRIES) | Entry index |
| wr_data_i | input | KEY_W | Key word to store |
| wr_valid_i | input | 1 | Validity bit to store |
| cmp_en_i | input | 1 | Compare strobe |
| cmp_key_i | input | KEY_W | Search key |
| full_ni | input | 1 | Full input from the higher-priority device, active low |
| full_n_o | output | 1 | Chained full flag, active low |
| mm_up_ni | input | 1 | Upstream match indication, active low |
| mm_pull_o | output | 1 | Pull-down enable for the shared multiple-match line |
| match_n_o | output | 1 | Local match valid, active low |
| hit_aux_o | output | 1 | Match type: 1 when only the auxiliary table hit |

## Verification
`full_n_o`, `match_n_o` and `hit_aux_o` are registers. Each becomes visible one clock edge after the cycle that carried the write or the compare, so the bench drives just after a rising edge and compares on the following falling edge. `mm_pull_o` combines the registered hit count with the live `mm_up_ni`. In the two-device chain, the lower device's threshold therefore follows the upper device's `match_n_o` in the same cycle the upper device's result appears, and the reference model evaluates it that way on every falling edge. The same-cycle write-and-compare case is checked against the contents held before the edge.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [1:0] {
    HITS_NONE = 2'd0,
    HITS_ONE  = 2'd1,
    HITS_MANY = 2'd2
  } hits_e;

  function automatic hits_e hits_bump(hits_e cur);
    case (cur)
      HITS_NONE: hits_bump = HITS_ONE;
      default:   hits_bump = HITS_MANY;
    endcase
  endfunction
endpackage

// File: rtl/cam_bank.sv
module cam_bank #(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int KEY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [KEY_W-1:0] data_i,
  input  logic             valid_i,
  input  logic [KEY_W-1:0] key_i,
  output logic [DEPTH-1:0] hit_o,
  output logic [DEPTH-1:0] valid_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [KEY_W-1:0] key_q;
    logic             vld_q;
    logic             sel;

    assign sel = we_i && (addr_i == AW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        key_q <= '0;
        vld_q <= 1'b0;
      end else if (sel) begin
        key_q <= data_i;
        vld_q <= valid_i;
      end
    end

    assign hit_o[g]   = vld_q && (key_q == key_i);
    assign valid_o[g] = vld_q;
  end
endmodule

// File: rtl/cam_hit_count.sv
module cam_hit_count
  import cam_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] hits_i,
  output hits_e        level_o
);
  always_comb begin
    level_o = HITS_NONE;
    for (int i = 0; i < N; i++) begin
      if (hits_i[i]) level_o = hits_bump(level_o);
    end
  end
endmodule

// File: rtl/cam_cascade.sv
module cam_cascade
  import cam_pkg::*;
#(
  parameter int ENTRIES     = 8,
  parameter int AUX_ENTRIES = 4,
  parameter int KEY_W       = 8,
  localparam int AW         = $clog2(ENTRIES),
  localparam int XAW        = $clog2(AUX_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_aux_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [KEY_W-1:0] wr_data_i,
  input  logic             wr_valid_i,
  input  logic             cmp_en_i,
  input  logic [KEY_W-1:0] cmp_key_i,
  input  logic             full_ni,
  output logic             full_n_o,
  input  logic             mm_up_ni,
  output logic             mm_pull_o,
  output logic             match_n_o,
  output logic             hit_aux_o
);
  logic [ENTRIES-1:0]     main_hit, main_valid, valid_next;
  logic [AUX_ENTRIES-1:0] aux_hit, aux_valid_unused;
  logic                   main_we, aux_we;
  hits_e                  level_d, level_q;
  logic                   full_d;

  assign main_we = wr_en_i && !wr_aux_i;
  assign aux_we  = wr_en_i && wr_aux_i;

  cam_bank #(.DEPTH(ENTRIES), .AW(AW), .KEY_W(KEY_W)) i_main (
    .clk_i, .rst_ni,
    .we_i(main_we), .addr_i(wr_addr_i), .data_i(wr_data_i), .valid_i(wr_valid_i),
    .key_i(cmp_key_i), .hit_o(main_hit), .valid_o(main_valid)
  );

  cam_bank #(.DEPTH(AUX_ENTRIES), .AW(XAW), .KEY_W(KEY_W)) i_aux (
    .clk_i, .rst_ni,
    .we_i(aux_we), .addr_i(wr_addr_i[XAW-1:0]), .data_i(wr_data_i), .valid_i(wr_valid_i),
    .key_i(cmp_key_i), .hit_o(aux_hit), .valid_o(aux_valid_unused)
  );

  cam_hit_count #(.N(ENTRIES)) i_count (
    .hits_i(main_hit), .level_o(level_d)
  );

  // occupancy as it stands after the pending write
  always_comb begin
    valid_next = main_valid;
    if (main_we) valid_next[wr_addr_i] = wr_valid_i;
    full_d = !((&valid_next) && !full_ni);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_n_o  <= 1'b1;
      match_n_o <= 1'b1;
      hit_aux_o <= 1'b0;
      level_q   <= HITS_NONE;
    end else begin
      if (wr_en_i) full_n_o <= full_d;
      if (cmp_en_i) begin
        match_n_o <= !((|main_hit) || (|aux_hit));
        hit_aux_o <= (|aux_hit) && !(|main_hit);
        level_q   <= level_d;
      end
    end
  end

  // upstream match lowers the threshold to one
  assign mm_pull_o = mm_up_ni ? (level_q == HITS_MANY) : (level_q != HITS_NONE);
endmodule

// File: rtl/cam_cascade_chk.sv
module cam_cascade_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic cmp_en_i,
  input logic full_ni,
  input logic full_n_o,
  input logic mm_up_ni,
  input logic mm_pull_o,
  input logic match_n_o,
  input logic hit_aux_o
);
  a_r9_upstream_forces_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full_ni) |=> full_n_o);

  a_r10_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(full_n_o));

  a_r10_match_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_en_i |=> ($stable(match_n_o) && $stable(hit_aux_o)));

  a_r5_type_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_aux_o |-> !match_n_o);

  a_r8_pull_needs_main_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_pull_o |-> (!match_n_o && !hit_aux_o));

  a_r6_pull_local_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_up_ni && mm_pull_o) |-> !match_n_o);
endmodule

bind cam_cascade cam_cascade_chk i_chk (.*);

// File: tb/test_cam_cascade.sv
module test_cam_cascade;
  localparam int CLK_P = 10;
  localparam int NE = 8;
  localparam int NX = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] wr_en = '0;
  logic       wr_aux = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wr_valid = 1'b0;
  logic       cmp_en = 1'b0;
  logic [7:0] cmp_key = '0;
  logic [1:0] full_n, pull, mv, haux;
  logic       mm_line;

  int total = 0, bad = 0;
  bit run = 0, done = 0;

  always #(CLK_P/2) clk = ~clk;

  cam_cascade #(.ENTRIES(NE), .AUX_ENTRIES(NX), .KEY_W(8)) i_cam_cascade (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en[0]), .wr_aux_i(wr_aux),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_valid_i(wr_valid),
    .cmp_en_i(cmp_en), .cmp_key_i(cmp_key), .full_ni(1'b0), .full_n_o(full_n[0]),
    .mm_up_ni(1'b1), .mm_pull_o(pull[0]), .match_n_o(mv[0]), .hit_aux_o(haux[0])
  );

  cam_cascade #(.ENTRIES(NE), .AUX_ENTRIES(NX), .KEY_W(8)) i_cam_cascade_lo (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en[1]), .wr_aux_i(wr_aux),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_valid_i(wr_valid),
    .cmp_en_i(cmp_en), .cmp_key_i(cmp_key), .full_ni(full_n[0]), .full_n_o(full_n[1]),
    .mm_up_ni(mv[0]), .mm_pull_o(pull[1]), .match_n_o(mv[1]), .hit_aux_o(haux[1])
  );

  assign mm_line = !(pull[0] || pull[1]);

  // behavioural reference
  int unsigned m_data[2][NE];
  bit          m_v[2][NE];
  int unsigned x_data[2][NX];
  bit          x_v[2][NX];
  bit          e_full[2], e_mv[2], e_aux[2];
  int          e_cnt[2];

  always @(posedge clk or negedge rst_n) begin : mdl
    bit f0, all, ah;
    int c;
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        for (int i = 0; i < NE; i++) begin m_v[k][i] = 0; m_data[k][i] = 0; end
        for (int i = 0; i < NX; i++) begin x_v[k][i] = 0; x_data[k][i] = 0; end
        e_full[k] = 1; e_mv[k] = 1; e_aux[k] = 0; e_cnt[k] = 0;
      end
    end else begin
      f0 = e_full[0];
      for (int k = 0; k < 2; k++) begin
        if (cmp_en) begin
          c = 0; ah = 0;
          for (int i = 0; i < NE; i++) if (m_v[k][i] && m_data[k][i] == cmp_key) c++;
          for (int i = 0; i < NX; i++) if (x_v[k][i] && x_data[k][i] == cmp_key) ah = 1;
          e_cnt[k] = (c > 2) ? 2 : c;
          e_mv[k]  = !(c > 0 || ah);
          e_aux[k] = ah && (c == 0);
        end
      end
      for (int k = 0; k < 2; k++) begin
        if (wr_en[k]) begin
          if (wr_aux) begin
            x_data[k][wr_addr % NX] = wr_data; x_v[k][wr_addr % NX] = wr_valid;
          end else begin
            m_data[k][wr_addr] = wr_data; m_v[k][wr_addr] = wr_valid;
          end
          all = 1;
          for (int i = 0; i < NE; i++) all = all && m_v[k][i];
          e_full[k] = !(all && !((k == 0) ? 1'b0 : f0));
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run) begin
      for (int k = 0; k < 2; k++) begin
        bit up, ep;
        up = (k == 0) ? 1'b1 : e_mv[0];
        ep = up ? (e_cnt[k] >= 2) : (e_cnt[k] >= 1);
        chk("R9 full_n", full_n[k], e_full[k]);
        chk("R4 match_n", mv[k], e_mv[k]);
        chk("R5 hit_aux", haux[k], e_aux[k]);
        chk(up ? "R6 pull" : "R7 pull", pull[k], ep);
      end
      chk("R8 mm_line", mm_line, !((e_cnt[0] >= 2) ||
          ((e_mv[0] ? (e_cnt[1] >= 2) : (e_cnt[1] >= 1)))));
    end
  end

  task automatic wr(int dev, bit aux, int addr, int data, bit v);
    wr_en = '0; wr_en[dev] = 1'b1; wr_aux = aux;
    wr_addr = 3'(addr); wr_data = 8'(data); wr_valid = v;
    @(posedge clk); #1;
    wr_en = '0;
  endtask

  task automatic cmp(int key);
    cmp_en = 1'b1; cmp_key = 8'(key);
    @(posedge clk); #1;
    cmp_en = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();
    // R1 reset state
    chk("R1 full_n", full_n[0], 1); chk("R1 match_n", mv[0], 1);
    chk("R1 hit_aux", haux[0], 0);  chk("R1 pull", pull[0], 0);
    run = 1;
    cmp(0); settle();
    chk("R1 no match after reset", mv[0] & mv[1], 1);

    wr(0, 0, 0, 8'h11, 1); wr(0, 0, 1, 8'h22, 1);
    cmp(8'h11); settle();
    chk("R2 stored entry hits", mv[0], 0);
    chk("R6 single hit no pull", pull[0], 0);

    wr(0, 0, 2, 8'h11, 1);
    cmp(8'h11); settle();
    chk("R6 two hits pull", pull[0], 1);

    wr(1, 0, 5, 8'h11, 1);
    cmp(8'h11); settle();
    chk("R7 upstream match one hit pull", pull[1], 1);
    chk("R4 local match not gated", mv[1], 0);
    cmp(8'h22); settle();
    chk("R7 zero hits no pull", pull[1], 0);
    cmp(8'h33); settle();
    chk("R4 both miss", mv[0], 1);

    wr(1, 1, 1, 8'h77, 1);
    cmp(8'h77); settle();
    chk("R5 aux only hit", haux[1], 1);
    chk("R4 aux hit gives match", mv[1], 0);
    chk("R8 aux hit no pull", pull[1], 0);
    wr(0, 1, 0, 8'h22, 1);
    cmp(8'h22); settle();
    chk("R5 main takes precedence", haux[0], 0);

    wr(0, 0, 0, 8'h11, 0);
    cmp(8'h11); settle();
    chk("R3 invalid entry skipped", pull[0], 0);

    // write and compare in one cycle
    wr_en = 2'b01; wr_aux = 0; wr_addr = 3'd1; wr_data = 8'h44; wr_valid = 1;
    cmp_en = 1; cmp_key = 8'h44;
    @(posedge clk); #1; wr_en = '0; cmp_en = 0;
    settle();
    chk("R2 compare sees old contents", mv[0], 1);
    cmp(8'h44); settle();
    chk("R2 new contents after edge", mv[0], 0);
    cmp_key = 8'h33;
    repeat (2) @(posedge clk);
    settle();
    chk("R10 match holds without compare", mv[0], 0);

    for (int i = 0; i < NE; i++) wr(0, 0, i, 8'h80 + i, 1);
    settle();
    chk("R9 top device full", full_n[0], 0);
    for (int i = 0; i < NE; i++) wr(1, 0, i, 8'h90 + i, 1);
    settle();
    chk("R9 chained full", full_n[1], 0);
    wr(0, 0, 3, 8'h83, 0); settle();
    chk("R9 not full after invalidate", full_n[0], 1);
    chk("R10 full holds without write", full_n[1], 0);
    wr(1, 0, 0, 8'h90, 1); settle();
    chk("R9 upstream forces high", full_n[1], 1);
    wr(1, 1, 2, 8'h55, 1); settle();
    chk("R9 aux write keeps not full", full_n[1], 1);

    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = $urandom_range(0, 5);
      wr_en = '0;
      if ($urandom_range(0, 1)) wr_en[$urandom_range(0, 1)] = 1'b1;
      wr_aux = ($urandom_range(0, 3) == 0);
      wr_addr = 3'($urandom_range(0, NE - 1));
      wr_data = (sel < 4) ? 8'(8'h80 + sel) : ((sel == 4) ? 8'h11 : 8'h77);
      wr_valid = ($urandom_range(0, 4) != 0);
      cmp_en = $urandom_range(0, 1);
      cmp_key = 8'(8'h80 + $urandom_range(0, 3));
      if ($urandom_range(0, 4) == 0) cmp_key = 8'h11;
      @(posedge clk); #1;
    end
    wr_en = '0; cmp_en = 0;
    settle();
    done = 1;
    summary();
    $finish;
  end
endmodule